// File: doc/BRIEF.md
# Serial Receive Frame Sequencer

This block assembles one serial character per frame from a line that is sampled only when an external rate generator raises a one-cycle sample strobe. In asynchronous operation each frame is a start bit, seven or eight data bits sent least significant bit first, an optional parity bit and one stop bit. In clocked synchronous operation there are no framing bits: every strobe carries a data bit, and the character ends with its last data bit. Line errors are reported on two sticky flags that software-facing logic elsewhere clears with a strobe.

The assembled character leaves the block as a stream beat: `done_o` is the valid qualifier and `data_o` the payload. A serial line cannot be paused, so the beat carries no ready input and there is no back-pressure. The beat is valid for exactly one clock. `data_o` then holds its value until the next beat, which gives a slow consumer a full character time to copy it. When the start-bit sample is high, the frame is a false start. The block then asks the rate generator, through `clk_stop_o`, to stop strobing until it sees the next falling edge. The mode inputs must stay stable for the whole of a frame.

Top module: `srx_frame_seq`

## Requirements
- R1: In asynchronous mode, a high line on the start-bit strobe abandons the frame. `clk_stop_o` pulses for one cycle, starting one clock after that strobe. No `done_o` is produced, and the next strobe is treated as a start-bit sample again.
- R2: A character has 7 data bits when `mode_short_i` is 1 and 8 data bits when it is 0.
- R3: Data bits arrive least significant first. In 8-bit mode the first data bit sampled appears on `data_o[0]` and the last on `data_o[7]`.
- R4: In asynchronous 7-bit mode the character appears on `data_o[6:0]` with `data_o[7]` = 0. In synchronous 7-bit mode the character appears on `data_o[7:1]` with `data_o[0]` = 0.
- R5: With `sync_i` = 1, the first strobe of a frame is data bit 0. `done_o` follows the last data bit, with no start, parity or stop phase, and the frame leaves both error flags unchanged.
- R6: With `par_en_i` = 1 in asynchronous mode, exactly one parity bit is sampled after the data bits. `par_odd_i` = 0 expects an even count of ones over the data and parity bits, and 1 expects an odd count. A mismatch sets `per_o` when the stop bit is high.
- R7: A low stop bit sets `fer_o`, and in that frame `per_o` is not set whatever the parity bit was.
- R8: `done_o` is a one-cycle pulse. It rises one clock after the strobe of the stop bit, or after the strobe of the last synchronous data bit. `data_o` updates in that same cycle, also for frames with errors, and is stable at all other times.
- R9: `fer_o` and `per_o` stay set until `err_clr_i` is high at a clock edge. A flag being set in the same cycle as `err_clr_i` stays set.
- R10: After reset `data_o` = 0 and `done_o`, `clk_stop_o`, `fer_o` and `per_o` are 0.
- R11: The line is looked at only in cycles where `smp_i` = 1. Line activity between strobes changes neither the character nor the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial receive line |
| smp_i | input | 1 | Bit sample strobe, one cycle per bit |
| mode_short_i | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| par_en_i | input | 1 | Parity bit present (asynchronous mode only) |
| par_odd_i | input | 1 | 0 = even parity, 1 = odd parity |
| sync_i | input | 1 | 1 = clocked synchronous mode, no framing bits |
| err_clr_i | input | 1 | Clears both sticky error flags |
| data_o | output | 8 | Received character, payload of the output beat |
| done_o | output | 1 | One-cycle valid pulse for `data_o` |
| clk_stop_o | output | 1 | One-cycle request to stop the sample strobe after a false start |
| fer_o | output | 1 | Sticky framing error |
| per_o | output | 1 | Sticky parity error |

## Verification
The bench puts random noise on the line between strobes. A sequencer that advanced on clock edges rather than strobes would then scramble characters. Short characters are sent in both modes with bit 7 of the source set: inserting at the wrong position would leak that bit into `data_o[7]` in asynchronous mode, or misalign the character by one in synchronous mode. One frame has both a bad stop and a bad parity bit, and one error lands together with a clear strobe. These catch an error check that ignores stop-before-parity priority and a clear that wins over a set. False starts and synchronous frames check that a high start sample never yields a character, and that a synchronous frame stops after its data bits with the flags unchanged.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_DATA  = 2'd1,
    PH_PAR   = 2'd2,
    PH_STOP  = 2'd3
  } srx_phase_e;
endpackage

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          sh_en_i,
  input  logic          ins_low_i,
  input  logic          bit_i,
  output logic [DW-1:0] nxt_o
);
  logic [DW-1:0] sr_q;
  logic [DW-1:0] base;

  always_comb begin
    base  = clr_i ? '0 : sr_q;
    nxt_o = base;
    if (sh_en_i) begin
      nxt_o = base >> 1;
      if (ins_low_i) nxt_o[DW-2] = bit_i;
      else           nxt_o[DW-1] = bit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= nxt_o;
  end
endmodule

// File: rtl/srx_parity.sv
module srx_parity (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic fold_i,
  input  logic bit_i,
  output logic acc_o
);
  logic acc_q;
  logic acc_nxt;

  always_comb begin
    acc_nxt = clr_i ? 1'b0 : acc_q;
    if (fold_i) acc_nxt = acc_nxt ^ bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_nxt;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_i,
  input  logic line_i,
  input  logic short_i,
  input  logic par_en_i,
  input  logic sync_i,
  output logic clr_o,
  output logic shift_o,
  output logic fold_o,
  output logic fin_o,
  output logic stop_chk_o,
  output logic abort_o
);
  localparam int CW = $clog2(DW + 1);

  srx_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] nbits;

  assign nbits = short_i ? CW'(DW - 1) : CW'(DW);

  always_comb begin
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    clr_o      = 1'b0;
    shift_o    = 1'b0;
    fold_o     = 1'b0;
    fin_o      = 1'b0;
    stop_chk_o = 1'b0;
    abort_o    = 1'b0;
    if (smp_i) begin
      unique case (ph_q)
        PH_START: begin
          if (sync_i) begin
            clr_o   = 1'b1;
            shift_o = 1'b1;
            fold_o  = 1'b1;
            cnt_d   = nbits - CW'(1);
            ph_d    = PH_DATA;
          end else if (line_i) begin
            abort_o = 1'b1;
          end else begin
            clr_o = 1'b1;
            cnt_d = nbits;
            ph_d  = PH_DATA;
          end
        end
        PH_DATA: begin
          shift_o = 1'b1;
          fold_o  = 1'b1;
          cnt_d   = cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            if (sync_i) begin
              fin_o = 1'b1;
              ph_d  = PH_START;
            end else if (par_en_i) begin
              ph_d = PH_PAR;
            end else begin
              ph_d = PH_STOP;
            end
          end
        end
        PH_PAR: begin
          fold_o = 1'b1;
          ph_d   = PH_STOP;
        end
        PH_STOP: begin
          stop_chk_o = 1'b1;
          fin_o      = 1'b1;
          ph_d       = PH_START;
        end
        default: ph_d = PH_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_START;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/srx_frame_seq.sv
module srx_frame_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic          smp_i,
  input  logic          mode_short_i,
  input  logic          par_en_i,
  input  logic          par_odd_i,
  input  logic          sync_i,
  input  logic          err_clr_i,
  output logic [DW-1:0] data_o,
  output logic          done_o,
  output logic          clk_stop_o,
  output logic          fer_o,
  output logic          per_o
);
  logic          clr, shift, fold, fin, stop_chk, abort_req;
  logic          acc;
  logic [DW-1:0] sr_nxt;
  logic          fer_set, per_set;

  srx_ctrl #(.DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_i      (smp_i),
    .line_i     (line_i),
    .short_i    (mode_short_i),
    .par_en_i   (par_en_i),
    .sync_i     (sync_i),
    .clr_o      (clr),
    .shift_o    (shift),
    .fold_o     (fold),
    .fin_o      (fin),
    .stop_chk_o (stop_chk),
    .abort_o    (abort_req)
  );

  srx_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .sh_en_i   (shift),
    .ins_low_i (mode_short_i & ~sync_i),
    .bit_i     (line_i),
    .nxt_o     (sr_nxt)
  );

  srx_parity u_par (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .fold_i (fold),
    .bit_i  (line_i),
    .acc_o  (acc)
  );

  assign fer_set = stop_chk & ~line_i;
  assign per_set = stop_chk & line_i & par_en_i & (acc ^ par_odd_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o     <= '0;
      done_o     <= 1'b0;
      clk_stop_o <= 1'b0;
      fer_o      <= 1'b0;
      per_o      <= 1'b0;
    end else begin
      done_o     <= fin;
      clk_stop_o <= abort_req;
      if (fin) data_o <= sr_nxt;
      if (fer_set)        fer_o <= 1'b1;
      else if (err_clr_i) fer_o <= 1'b0;
      if (per_set)        per_o <= 1'b1;
      else if (err_clr_i) per_o <= 1'b0;
    end
  end
endmodule

// File: rtl/srx_frame_seq_chk.sv
module srx_frame_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_i,
  input logic          smp_i,
  input logic          mode_short_i,
  input logic          sync_i,
  input logic          err_clr_i,
  input logic [DW-1:0] data_o,
  input logic          done_o,
  input logic          clk_stop_o,
  input logic          fer_o,
  input logic          per_o
);
  assert_done_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(smp_i));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(data_o));

  assert_stop_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop_o |-> ($past(smp_i) && $past(line_i) && !$past(sync_i)));

  assert_no_beat_on_abort_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, clk_stop_o}));

  assert_fer_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fer_o) |-> (done_o && !$past(sync_i)));

  assert_per_good_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_o) |-> (done_o && $past(line_i)));

  assert_fer_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fer_o) |-> $past(err_clr_i));

  assert_per_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(per_o) |-> $past(err_clr_i));

  assert_short_top_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(mode_short_i) && !$past(sync_i)) |-> !data_o[DW-1]);
endmodule

bind srx_frame_seq srx_frame_seq_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_i       (line_i),
  .smp_i        (smp_i),
  .mode_short_i (mode_short_i),
  .sync_i       (sync_i),
  .err_clr_i    (err_clr_i),
  .data_o       (data_o),
  .done_o       (done_o),
  .clk_stop_o   (clk_stop_o),
  .fer_o        (fer_o),
  .per_o        (per_o)
);

// File: tb/sim_srx_frame_seq.sv
module sim_srx_frame_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_i = 1'b1, smp_i = 1'b0;
  logic       mode_short_i = 1'b0, par_en_i = 1'b0, par_odd_i = 1'b0;
  logic       sync_i = 1'b0, err_clr_i = 1'b0;
  logic [7:0] data_o;
  logic       done_o, clk_stop_o, fer_o, per_o;
  int         n_chk = 0, n_err = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  srx_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .smp_i(smp_i),
    .mode_short_i(mode_short_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .sync_i(sync_i), .err_clr_i(err_clr_i), .data_o(data_o), .done_o(done_o),
    .clk_stop_o(clk_stop_o), .fer_o(fer_o), .per_o(per_o)
  );

  function automatic logic [7:0] exp_data(input logic [7:0] d, input bit sh, input bit sy);
    if (!sh)     return d;
    else if (sy) return {d[6:0], 1'b0};
    else         return {1'b0, d[6:0]};
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input bit sh, input bit odd, input bit bad);
    logic ones;
    ones = sh ? ^d[6:0] : ^d;
    return ones ^ odd ^ bad;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      line_i = 1'($urandom);
    end
  endtask

  task automatic strobe(input logic b);
    @(negedge clk);
    line_i = b;
    smp_i  = 1'b1;
    @(negedge clk);
    smp_i  = 1'b0;
    line_i = 1'($urandom);
  endtask

  task automatic clr_flags();
    @(negedge clk);
    err_clr_i = 1'b1;
    @(negedge clk);
    err_clr_i = 1'b0;
    chk(!fer_o && !per_o, "R9 clear", {fer_o, per_o}, 0);
  endtask

  task automatic frame(input logic [7:0] d, input bit sh, input bit pen, input bit odd,
                       input bit sy, input bit bad_stop, input bit bad_par,
                       input bit clr_with_stop, input int maxgap);
    logic bits [12];
    int   n = 0;
    logic ef, ep, f0, p0;
    @(negedge clk);
    mode_short_i = sh; par_en_i = pen; par_odd_i = odd; sync_i = sy;
    f0 = fer_o; p0 = per_o;
    if (!sy) begin bits[n] = 1'b0; n++; end
    for (int i = 0; i < (sh ? 7 : 8); i++) begin bits[n] = d[i]; n++; end
    if (!sy && pen) begin bits[n] = par_bit(d, sh, odd, bad_par); n++; end
    if (!sy) begin bits[n] = ~bad_stop; n++; end
    for (int i = 0; i < n; i++) begin
      if (i == n - 1 && clr_with_stop) err_clr_i = 1'b1;
      strobe(bits[i]);
      err_clr_i = 1'b0;
      if (i < n - 1) begin
        chk(!done_o && !clk_stop_o, "R11 no beat mid-frame", done_o, 0);
        gap($urandom_range(maxgap, 0));
      end
    end
    if (sy) begin
      ef = f0; ep = p0;
    end else begin
      ef = bad_stop | (clr_with_stop ? 1'b0 : f0);
      ep = (!bad_stop && pen && bad_par) | (clr_with_stop ? 1'b0 : p0);
    end
    chk(done_o === 1'b1, "R8 done pulse", done_o, 1);
    chk(data_o === exp_data(d, sh, sy), sy ? "R5 R3 R4 sync data" : "R2 R3 R4 async data",
        data_o, exp_data(d, sh, sy));
    chk(fer_o === ef, "R7 framing flag", fer_o, ef);
    chk(per_o === ep, "R6 parity flag", per_o, ep);
    @(negedge clk);
    chk(done_o === 1'b0, "R8 one-cycle done", done_o, 0);
    chk(data_o === exp_data(d, sh, sy), "R8 data holds", data_o, exp_data(d, sh, sy));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] seed;
    seed = 8'($urandom(32'd4271));
    repeat (3) @(negedge clk);
    chk(data_o == 0 && !done_o && !clk_stop_o && !fer_o && !per_o, "R10 reset state",
        {data_o, done_o, clk_stop_o, fer_o, per_o}, 0);
    rst_n = 1'b1;
    gap(2);

    // directed corner cases
    frame(8'hA5, 0, 0, 0, 0, 0, 0, 0, 3);   // R3 8-bit LSB first
    frame(8'hD5, 1, 0, 0, 0, 0, 0, 0, 2);   // R4 async short drops bit 7
    frame(8'hB3, 0, 1, 0, 0, 0, 0, 0, 1);   // R6 even good
    frame(8'hB3, 1, 1, 1, 0, 0, 0, 0, 1);   // R6 odd good
    frame(8'h6E, 0, 1, 0, 0, 0, 1, 0, 2);   // R6 bad parity sets per
    gap(5);
    chk(per_o === 1'b1, "R9 per sticky over idle", per_o, 1);
    clr_flags();
    frame(8'h19, 0, 1, 1, 0, 1, 1, 0, 1);   // R7 bad stop masks parity
    clr_flags();
    frame(8'h3C, 0, 0, 0, 1, 0, 0, 0, 2);   // R5 sync 8-bit
    frame(8'hC7, 1, 1, 0, 1, 1, 1, 0, 2);   // R5 R4 sync short, flags untouched
    frame(8'h01, 0, 0, 0, 0, 1, 0, 1, 0);   // R9 set wins over clear
    clr_flags();

    // R1 false start
    @(negedge clk);
    sync_i = 1'b0;
    strobe(1'b1);
    chk(clk_stop_o === 1'b1 && done_o === 1'b0, "R1 stop request", {clk_stop_o, done_o}, 2);
    @(negedge clk);
    chk(clk_stop_o === 1'b0, "R1 stop request one cycle", clk_stop_o, 0);
    frame(8'h5A, 0, 0, 0, 0, 0, 0, 0, 1);   // R1 next start accepted

    // constrained random frames
    for (int k = 0; k < 300; k++) begin
      frame(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            ($urandom_range(3, 0) == 0), ($urandom_range(5, 0) == 0),
            ($urandom_range(3, 0) == 0), 1'b0, 3);
      clr_flags();
      if ($urandom_range(7, 0) == 0) begin
        @(negedge clk);
        sync_i = 1'b0;
        strobe(1'b1);
        chk(clk_stop_o === 1'b1, "R1 random false start", clk_stop_o, 1);
      end
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule